// File: doc/BRIEF.md
# Ternary Word-Adder Sequencer for Multistate Cells

This block adds two unsigned ternary operands inside one word of multistate memory cells. It does not add in logic. It steps the cells through a fixed sequence of commands, and the cells do the arithmetic. Each cell can hold one of six resistance states, indexed 0 to 5. A RESET pulse whose level is the sum of an offset and the two operand digits leaves the cell in the state whose index equals that level. After each pulse the controller reads the cell back. It then writes the cell to a valid trit: the digit sum modulo three for the sum cell, or the carry for the cells above it. Every pulse and every write is preceded by a SET to the low-resistance state, so that each result can be reproduced.

An N-trit addition uses N+1 cells. In round i, cell i forms sum digit i and every higher cell forms the carry out of digit i, all from the same digit pair. In the next round each active cell first reads its stored carry, and that carry selects the raised offset. When the last round is finished, a final read of every cell gives the result trits, and `done` pulses. The analog drive and the cell physics lie outside the block. Each cell receives a 3-bit command code and a 3-bit argument per cycle, and returns its present state index.

Top module: `tern_word_adder`

## Requirements
- R1: With the block idle and no error latched, a `start` seen at a clock edge makes the next cycle issue INIT (code 1) to every cell. INIT leaves a cell in the low-resistance state.
- R2: A RESET (code 3) or WRITE (code 5) to a cell is always issued in the cycle directly after a SET (code 2) to that same cell.
- R3: In round i, the RESET argument for each active cell is cin + a_i + b_i. Here a_i and b_i are the operand digits taken from bits [2i+1:2i], with codes 0, 1 and 2 only. cin is 0 in round 0. In later rounds, cin is 1 when the state the cell returned on its carry READ (code 4) at the start of that round was nonzero.
- R4: A carry cell that read a state of 3 or more after its pulse is written to state 1. Otherwise it is written to state 0.
- R5: The sum cell is written to the read state minus 3 when that state is 3 to 5, and to the read state unchanged when it is 0 to 2.
- R6: Round 0 runs the steps SET, RESET, READ, SET, WRITE. Every later round first runs a carry READ and then the same five steps. In round i, cells below i receive NOP (code 0).
- R7: Once `done` rises, `sum_trits[2k+1:2k]` holds trit k of a+b for k = 0..N, with trit N being the final carry. For example, 21 + 22 in base 3 gives 120.
- R8: After the last write-back, one cycle reads all cells. `done` is then high for exactly one cycle, with `busy` low. `busy` is high from the INIT cycle until that point.
- R9: A `start` that arrives while `busy` is high has no effect on the command stream or on the result.
- R10: A READ that returns state 6 or 7 latches `err`. All commands then become NOP, `done` never asserts, and `start` is ignored until reset.
- R11: While in reset and just after it, `busy`, `done` and `err` are low and every cell command is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition (taken only when idle) |
| op_a | input | 2*NTRIT | First operand, two bits per trit |
| op_b | input | 2*NTRIT | Second operand, two bits per trit |
| cell_rd | input | 3*(NTRIT+1) | Current state index of each cell |
| cell_cmd | output | 3*(NTRIT+1) | Command code per cell |
| cell_arg | output | 3*(NTRIT+1) | Pulse level or write target per cell |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky out-of-range read flag |
| sum_trits | output | 2*(NTRIT+1) | Result trits, two bits each |

## Verification
The properties take three things for granted. Operand digit codes are never 3. A cell applies each command at the clock edge where it is issued. A cell's reported state reflects the last RESET or WRITE it received. The stimulus meets these conditions by building operands only from digits 0 to 2 and by driving `cell_rd` from a behavioural cell model that follows the commands exactly. An out-of-range state is produced only by a deliberate fault switch. The bench predicts every cycle's commands and arguments from plain integer arithmetic on the digits and carries, and it compares them against the block on every clock.

// File: rtl/tadd_pkg.sv
package tadd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_INIT  = 3'd1,
        CMD_SET   = 3'd2,
        CMD_RESET = 3'd3,
        CMD_READ  = 3'd4,
        CMD_WRITE = 3'd5
    } cell_cmd_e;

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_INIT  = 4'd1,
        PH_RDC   = 4'd2,
        PH_SET1  = 4'd3,
        PH_PULSE = 4'd4,
        PH_RD    = 4'd5,
        PH_SET2  = 4'd6,
        PH_WB    = 4'd7,
        PH_FIN   = 4'd8,
        PH_HALT  = 4'd9
    } phase_e;

    localparam logic [2:0] TOP_VALID_STATE = 3'd5;
    localparam logic [2:0] RADIX_STATE     = 3'd3;

endpackage

// File: rtl/tadd_digit_sel.sv
module tadd_digit_sel #(
    parameter int NTRIT = 4,
    parameter int RW    = 3
) (
    input  logic [2*NTRIT-1:0] op_a,
    input  logic [2*NTRIT-1:0] op_b,
    input  logic [RW-1:0]      round,
    output logic [1:0]         a_dig,
    output logic [1:0]         b_dig
);
    always_comb begin
        a_dig = 2'd0;
        b_dig = 2'd0;
        for (int k = 0; k < NTRIT; k++) begin
            if (round == RW'(k)) begin
                a_dig = op_a[2*k +: 2];
                b_dig = op_b[2*k +: 2];
            end
        end
    end
endmodule

// File: rtl/tadd_cell_lane.sv
module tadd_cell_lane
    import tadd_pkg::*;
#(
    parameter int IDX = 0,
    parameter int RW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic [RW-1:0] round,
    input  logic          clear,
    input  logic [1:0]    a_dig,
    input  logic [1:0]    b_dig,
    input  logic [2:0]    rd_state,
    output logic [2:0]    cmd,
    output logic [2:0]    arg,
    output logic          rd_bad,
    output logic [1:0]    trit
);
    typedef struct packed {
        logic       cin;
        logic [2:0] rd;
    } lane_t;

    lane_t     q, d;
    cell_cmd_e cmd_e;
    logic      act, is_sum;
    logic [2:0] level, tgt;

    assign act    = (32'(round) <= 32'(IDX));
    assign is_sum = (32'(round) == 32'(IDX));
    assign level  = {2'b00, q.cin} + {1'b0, a_dig} + {1'b0, b_dig};

    always_comb begin
        if (q.rd >= RADIX_STATE) tgt = is_sum ? (q.rd - RADIX_STATE) : 3'd1;
        else                     tgt = is_sum ? q.rd : 3'd0;
    end

    always_comb begin
        cmd_e = CMD_NOP;
        arg   = 3'd0;
        case (phase)
            PH_INIT:  cmd_e = CMD_INIT;
            PH_RDC:   if (act) cmd_e = CMD_READ;
            PH_SET1,
            PH_SET2:  if (act) cmd_e = CMD_SET;
            PH_PULSE: if (act) begin cmd_e = CMD_RESET; arg = level; end
            PH_RD:    if (act) cmd_e = CMD_READ;
            PH_WB:    if (act) begin cmd_e = CMD_WRITE; arg = tgt; end
            PH_FIN:   cmd_e = CMD_READ;
            default:  cmd_e = CMD_NOP;
        endcase
    end
    assign cmd    = cmd_e;
    assign rd_bad = (cmd_e == CMD_READ) && (rd_state > TOP_VALID_STATE);
    assign trit   = rd_state[1:0];

    always_comb begin
        d = q;
        if (clear) begin
            d.cin = 1'b0;
            d.rd  = 3'd0;
        end else if (phase == PH_RDC && act) begin
            d.cin = (rd_state != 3'd0);
        end else if (phase == PH_RD && act) begin
            d.rd = rd_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    set_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RESET) |-> ($past(cmd) == CMD_SET));
    // R2
    set_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> ($past(cmd) == CMD_SET));
    // R3
    pulse_level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RESET) |-> (arg <= TOP_VALID_STATE));
    // R4
    carry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE && !is_sum) |->
        (arg == (($past(rd_state, 2) >= RADIX_STATE) ? 3'd1 : 3'd0)));
    // R5
    sum_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE && is_sum) |->
        (arg == (($past(rd_state, 2) >= RADIX_STATE) ?
                 ($past(rd_state, 2) - RADIX_STATE) : $past(rd_state, 2))));
endmodule

// File: rtl/tern_word_adder.sv
module tern_word_adder
    import tadd_pkg::*;
#(
    parameter int NTRIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2*NTRIT-1:0]     op_a,
    input  logic [2*NTRIT-1:0]     op_b,
    input  logic [3*(NTRIT+1)-1:0] cell_rd,
    output logic [3*(NTRIT+1)-1:0] cell_cmd,
    output logic [3*(NTRIT+1)-1:0] cell_arg,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [2*(NTRIT+1)-1:0] sum_trits
);
    localparam int NCELL = NTRIT + 1;
    localparam int RW    = $clog2(NCELL);
    localparam logic [RW-1:0] LAST_ROUND = RW'(NTRIT - 1);

    typedef struct packed {
        phase_e              phase;
        logic [RW-1:0]       round;
        logic                done;
        logic                err;
        logic [2*NCELL-1:0]  res;
    } ctl_t;

    ctl_t q, d;
    logic [1:0]         a_dig, b_dig;
    logic [NCELL-1:0]   lane_bad;
    logic [2*NCELL-1:0] lane_trit;
    logic               clear;

    assign clear = (q.phase == PH_IDLE) && start;

    tadd_digit_sel #(.NTRIT(NTRIT), .RW(RW)) u_dsel (
        .op_a(op_a), .op_b(op_b), .round(q.round), .a_dig(a_dig), .b_dig(b_dig)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_lane
        tadd_cell_lane #(.IDX(c), .RW(RW)) u_lane (
            .clk(clk), .rst_n(rst_n), .phase(q.phase), .round(q.round),
            .clear(clear), .a_dig(a_dig), .b_dig(b_dig),
            .rd_state(cell_rd[3*c +: 3]),
            .cmd(cell_cmd[3*c +: 3]), .arg(cell_arg[3*c +: 3]),
            .rd_bad(lane_bad[c]), .trit(lane_trit[2*c +: 2])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE:  if (start) begin d.phase = PH_INIT; d.round = '0; end
            PH_INIT:  d.phase = PH_SET1;
            PH_RDC:   d.phase = PH_SET1;
            PH_SET1:  d.phase = PH_PULSE;
            PH_PULSE: d.phase = PH_RD;
            PH_RD:    d.phase = PH_SET2;
            PH_SET2:  d.phase = PH_WB;
            PH_WB: begin
                if (q.round == LAST_ROUND) d.phase = PH_FIN;
                else begin
                    d.phase = PH_RDC;
                    d.round = q.round + RW'(1);
                end
            end
            PH_FIN: begin
                d.res   = lane_trit;
                d.done  = 1'b1;
                d.phase = PH_IDLE;
            end
            default:  d.phase = PH_HALT;
        endcase
        if (|lane_bad) begin
            d.phase = PH_HALT;
            d.err   = 1'b1;
            d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.round <= '0;
            q.done  <= 1'b0;
            q.err   <= 1'b0;
            q.res   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.phase != PH_IDLE) && (q.phase != PH_HALT);
    assign done      = q.done;
    assign err       = q.err;
    assign sum_trits = q.res;

    // R1
    start_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !err) |=> (cell_cmd[2:0] == CMD_INIT));
    // R9
    init_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_cmd[2:0] == CMD_INIT) |-> $past(!busy));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !done && !busy));
    // R7
    for (genvar k = 0; k < NCELL; k++) begin : g_trit_chk
        trit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (sum_trits[2*k +: 2] != 2'd3));
    end
endmodule

// File: tb/tb_tern_word_adder.sv
module tb_tern_word_adder;
    localparam int NT = 4;
    localparam int NC = NT + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2*NT-1:0] op_a = '0, op_b = '0;
    logic [3*NC-1:0] cell_rd, dut_cmd, dut_arg;
    logic busy, done, err;
    logic [2*NC-1:0] sum_trits;

    int checks = 0, errs = 0;
    bit finished = 0;
    logic [2:0] mem [NC];
    bit fault_en = 0;
    int fault_cell = 0;

    logic [3*NC-1:0] q_cmd[$], q_arg[$];
    string q_tag[$];
    int scm[NC], sar[NC];

    always #10 clk = ~clk;

    tern_word_adder #(.NTRIT(NT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .cell_rd(cell_rd), .cell_cmd(dut_cmd), .cell_arg(dut_arg),
        .busy(busy), .done(done), .err(err), .sum_trits(sum_trits)
    );

    // behavioural cell model: LRS index 7, states 0..5
    always @(posedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (!rst_n) mem[c] <= 3'd7;
            else case (dut_cmd[3*c +: 3])
                3'd1, 3'd2: mem[c] <= 3'd7;
                3'd3, 3'd5: mem[c] <= dut_arg[3*c +: 3];
                default: ;
            endcase
        end
    end
    always_comb begin
        for (int c = 0; c < NC; c++)
            cell_rd[3*c +: 3] = (fault_en && c == fault_cell) ? 3'd6 : mem[c];
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input string tag);
        logic [3*NC-1:0] vc, va;
        for (int c = 0; c < NC; c++) begin
            vc[3*c +: 3] = 3'(scm[c]);
            va[3*c +: 3] = 3'(sar[c]);
        end
        q_cmd.push_back(vc); q_arg.push_back(va); q_tag.push_back(tag);
    endtask

    task automatic fill(input int lo, input int cmd, input int arg);
        for (int c = 0; c < NC; c++) begin
            scm[c] = (c >= lo) ? cmd : 0;
            sar[c] = (c >= lo) ? arg : 0;
        end
    endtask

    task automatic build(input logic [2*NT-1:0] a, input logic [2*NT-1:0] b,
                         output logic [2*NC-1:0] res);
        int cy, lvl;
        q_cmd.delete(); q_arg.delete(); q_tag.delete();
        cy = 0;
        fill(0, 1, 0); push("R1");
        for (int i = 0; i < NT; i++) begin
            lvl = int'(a[2*i +: 2]) + int'(b[2*i +: 2]) + cy;
            if (i > 0) begin fill(i, 4, 0); push("R6"); end
            fill(i, 2, 0);   push("R2");
            fill(i, 3, lvl); push("R3");
            fill(i, 4, 0);   push("R6");
            fill(i, 2, 0);   push("R2");
            fill(i, 5, lvl / 3); sar[i] = lvl % 3; push("R4 R5");
            res[2*i +: 2] = 2'(lvl % 3);
            cy = lvl / 3;
        end
        fill(0, 4, 0); push("R8");
        res[2*NT +: 2] = 2'(cy);
    endtask

    task automatic run_add(input logic [2*NT-1:0] a, input logic [2*NT-1:0] b,
                           input bit poke);
        logic [2*NC-1:0] exp_res;
        build(a, b, exp_res);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
        for (int k = 0; k < q_cmd.size(); k++) begin
            if (k > 0) @(negedge clk);
            check(dut_cmd === q_cmd[k], q_tag[k], "cmd", 64'(dut_cmd), 64'(q_cmd[k]));
            check(dut_arg === q_arg[k], q_tag[k], "arg", 64'(dut_arg), 64'(q_arg[k]));
            check(done === 1'b0, "R8", "done early", 64'(done), 64'd0);
            if (poke && k == 3) begin start = 1'b1; op_a = ~a; op_b = b ^ {NT{2'b01}}; end
            if (poke && k == 4) start = 1'b0;
            if (poke && k == 6) begin op_a = a; op_b = b; end
        end
        @(negedge clk);
        check(done === 1'b1, "R8", "done pulse", 64'(done), 64'd1);
        check(busy === 1'b0, "R8", "busy at done", 64'(busy), 64'd0);
        check(sum_trits === exp_res, poke ? "R9" : "R7", "result", 64'(sum_trits), 64'(exp_res));
        @(negedge clk);
        check(done === 1'b0, "R8", "done one cycle", 64'(done), 64'd0);
        check(dut_cmd === '0, "R8", "idle cmds", 64'(dut_cmd), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11", "flags in reset",
              64'({busy, done, err}), 64'd0);
        check(dut_cmd === '0, "R11", "cmds in reset", 64'(dut_cmd), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && err === 1'b0, "R11", "flags after reset",
              64'({busy, err}), 64'd0);

        // R7: 21 + 22 (base 3) = 120
        run_add(8'b00_00_10_01, 8'b00_00_10_10, 1'b0);
        check(sum_trits[5:0] === 6'b01_10_00, "R7", "example 120",
              64'(sum_trits[5:0]), 64'b01_10_00);
        // full carry chain 2222 + 2222
        run_add(8'b10_10_10_10, 8'b10_10_10_10, 1'b0);
        run_add(8'h00, 8'h00, 1'b0);
        run_add(8'b01_10_00_01, 8'b00_01_10_01, 1'b0);
        // R9: start pulsed while busy
        run_add(8'b10_00_01_10, 8'b01_10_10_00, 1'b1);

        // R10: out-of-range read halts the sequence
        fault_en = 1'b1; fault_cell = 2;
        @(negedge clk);
        op_a = 8'b01_01_01_01; op_b = 8'b01_01_01_01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(done === 1'b0, "R10", "no done after fault", 64'(done), 64'd0);
        end
        check(err === 1'b1, "R10", "err latched", 64'(err), 64'd1);
        check(busy === 1'b0, "R10", "halted", 64'(busy), 64'd0);
        check(dut_cmd === '0, "R10", "cmds NOP in halt", 64'(dut_cmd), 64'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(dut_cmd === '0 && err === 1'b1, "R10", "start ignored in halt",
              64'(dut_cmd), 64'd0);
        fault_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(err === 1'b0, "R11", "err cleared by reset", 64'(err), 64'd0);
        rst_n = 1'b1;
        run_add(8'b00_10_01_10, 8'b10_01_00_01, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule